// File: doc/BRIEF.md
# Descriptor-driven DMA channel engine

The engine runs the transfer of a single DMA channel. Its work is described by a descriptor: the address of the last source item, the address of the last destination item, and a 32-bit control word. The control word carries the item size, the source and destination increments, the arbitration exponent, the remaining item count and the transfer mode. Once software loads a descriptor and enables the channel, each accepted request moves items one at a time. An item is read from a synchronous memory read port and then written to a memory write port. The engine updates the count held in the control word as it goes. At the end it rewrites the mode to stop, clears the channel enable and pulses done.

Basic mode moves one arbitration block per request. Auto mode runs the whole transfer from a single request. Two channel attributes qualify requests: a mask that ignores hardware requests, and a burst-only setting that ignores single requests. A descriptor whose increments or sizes cannot work together is rejected with an error flag, and no data moves.

Top module: `dma_chan_engine`

## Requirements
- R1: After reset `ctrl_o` is 0, the channel is disabled, the engine is idle, and the read enable, write enable, done and error outputs are all low.
- R2: The control word fields are: destination increment in bits 31:30 and source increment in bits 27:26, each coded 0=byte, 1=halfword, 2=word, 3=none. Destination size is in bits 29:28 and source size in bits 25:24, coded 0=8, 1=16, 2=32 bits. The arbitration exponent is in bits 17:14, the item count minus one in bits 13:4, and the mode in bits 2:0, coded 0 stop, 1 basic, 2 auto. Each item moves 1<<size bytes.
- R3: The item being moved is at end_pointer − (remaining_minus_one << increment), so items are visited in ascending address order. An increment of 3 keeps the address at the end pointer.
- R4: A transfer moves count items, with count from 1 to 1024. After the last item, the count field reads 0, the mode field reads 0, the channel enable is 0, and `done_o` pulses high for one cycle.
- R5: After every 2^R items (R from bits 17:14, capped at 10) the engine returns to idle for at least one cycle. In basic mode, each block needs a new qualified request. Between blocks the count field holds the remaining items minus one, and the mode and enable are kept.
- R6: In auto mode, one qualified request runs the transfer to completion, even if the request drops at once.
- R7: When `req_mask_i` is high, hardware requests start nothing, and `sw_req_i` still starts the channel.
- R8: When `burst_only_i` is high, `hw_sreq_i` starts nothing, and `hw_breq_i` still starts the channel.
- R9: A descriptor is rejected if the source size is above 2, if the source and destination sizes differ, if a non-none increment is smaller than its size, or if the mode is not 0, 1 or 2. A request on a rejected descriptor sets `err_o`, clears the enable and moves no data. The control word is left unchanged.
- R10: While the mode is stop or the channel is disabled, requests have no effect.
- R11: Read data is taken one cycle after `rd_en_o`, in the same cycle as the matching `wr_en_o`. The item sits in the low bytes of the data, and read and write never occur in the same cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| cfg_wr_i | input | 1 | Load descriptor (accepted only while idle) |
| cfg_src_end_i | input | AW | Source end pointer |
| cfg_dst_end_i | input | AW | Destination end pointer |
| cfg_ctrl_i | input | 32 | Control word |
| en_set_i | input | 1 | Enable the channel |
| req_mask_i | input | 1 | Ignore hardware requests |
| burst_only_i | input | 1 | Ignore single hardware requests |
| sw_req_i | input | 1 | Software request |
| hw_sreq_i | input | 1 | Hardware single request |
| hw_breq_i | input | 1 | Hardware burst request |
| rd_en_o | output | 1 | Memory read strobe |
| rd_addr_o | output | AW | Memory read byte address |
| rd_data_i | input | 32 | Read data, valid the cycle after the strobe |
| wr_en_o | output | 1 | Memory write strobe |
| wr_addr_o | output | AW | Memory write byte address |
| wr_data_o | output | 32 | Write data, item in low bytes |
| wr_size_o | output | 2 | Item size code for the write |
| ctrl_o | output | 32 | Live control word (count and mode written back) |
| chan_en_o | output | 1 | Channel enable |
| busy_o | output | 1 | Engine moving an item |
| done_o | output | 1 | One-cycle completion pulse |
| err_o | output | 1 | Rejected descriptor flag |

## Verification
A wrong remaining count shows up in the very next read address as a shifted item. It also shows in the destination image when the transfer ends, since a fixed-address destination keeps only the last item written. A block counter that is off by one shows in basic mode within a single request, as a count field that stops at the wrong value. A stuck mode or enable is seen the cycle after the last write, through `ctrl_o` and `chan_en_o`. The sweep covers every legal pairing of size and increment, several counts, and several block sizes, so each decode path is compared against an arithmetic image of memory.

// File: rtl/dma_eng_pkg.sv
package dma_eng_pkg;
  typedef enum logic [1:0] {ST_IDLE, ST_RD, ST_WR} eng_st_e;

  localparam logic [2:0] MODE_STOP  = 3'd0;
  localparam logic [2:0] MODE_BASIC = 3'd1;
  localparam logic [2:0] MODE_AUTO  = 3'd2;
  localparam logic [1:0] INC_NONE   = 2'd3;
  localparam int CNT_LO = 4;
  localparam int CNT_W  = 10;

  function automatic logic cfg_bad(input logic [31:0] c);
    logic [1:0] di, dz, si, sz;
    logic [2:0] md;
    di = c[31:30]; dz = c[29:28]; si = c[27:26]; sz = c[25:24]; md = c[2:0];
    cfg_bad = (sz > 2'd2) || (dz != sz) ||
              ((si != INC_NONE) && (si < sz)) ||
              ((di != INC_NONE) && (di < dz)) ||
              (md > MODE_AUTO);
  endfunction
endpackage

// File: rtl/dma_addr_calc.sv
module dma_addr_calc #(
  parameter int AW = 32
) (
  input  logic [AW-1:0]                     end_addr_i,
  input  logic [dma_eng_pkg::CNT_W-1:0]     rem_m1_i,
  input  logic [1:0]                        inc_i,
  output logic [AW-1:0]                     addr_o
);
  logic [AW-1:0] off;
  always_comb begin
    off    = {{(AW-dma_eng_pkg::CNT_W){1'b0}}, rem_m1_i} << inc_i;
    addr_o = (inc_i == dma_eng_pkg::INC_NONE) ? end_addr_i : end_addr_i - off;
  end
endmodule

// File: rtl/dma_req_qual.sv
module dma_req_qual (
  input  logic sw_req_i,
  input  logic hw_sreq_i,
  input  logic hw_breq_i,
  input  logic req_mask_i,
  input  logic burst_only_i,
  output logic trig_o
);
  logic hw_req;
  assign hw_req = hw_breq_i | (hw_sreq_i & ~burst_only_i);
  assign trig_o = sw_req_i | (hw_req & ~req_mask_i);
endmodule

// File: rtl/dma_chan_engine.sv
module dma_chan_engine #(
  parameter int AW      = 32,
  parameter int ARB_MAX = 10
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          cfg_wr_i,
  input  logic [AW-1:0] cfg_src_end_i,
  input  logic [AW-1:0] cfg_dst_end_i,
  input  logic [31:0]   cfg_ctrl_i,
  input  logic          en_set_i,
  input  logic          req_mask_i,
  input  logic          burst_only_i,
  input  logic          sw_req_i,
  input  logic          hw_sreq_i,
  input  logic          hw_breq_i,
  output logic          rd_en_o,
  output logic [AW-1:0] rd_addr_o,
  input  logic [31:0]   rd_data_i,
  output logic          wr_en_o,
  output logic [AW-1:0] wr_addr_o,
  output logic [31:0]   wr_data_o,
  output logic [1:0]    wr_size_o,
  output logic [31:0]   ctrl_o,
  output logic          chan_en_o,
  output logic          busy_o,
  output logic          done_o,
  output logic          err_o
);
  import dma_eng_pkg::*;

  localparam int BLK_W = (ARB_MAX < 1) ? 1 : ARB_MAX;
  localparam logic [3:0] ARB_CAP = 4'(ARB_MAX);

  eng_st_e       st_q;
  logic [AW-1:0] src_end_q, dst_end_q;
  logic [31:0]   ctrl_q;
  logic          en_q, err_q, done_q, auto_run_q;
  logic [BLK_W-1:0] blk_q;

  logic [CNT_W-1:0] rem_m1;
  logic [2:0]       mode;
  logic [3:0]       arb_eff;
  logic [BLK_W:0]   blk_lim;
  logic             blk_last, trig, go;

  assign rem_m1  = ctrl_q[CNT_LO +: CNT_W];
  assign mode    = ctrl_q[2:0];
  assign arb_eff = (ctrl_q[17:14] > ARB_CAP) ? ARB_CAP : ctrl_q[17:14];
  assign blk_lim = ({{BLK_W{1'b0}}, 1'b1} << arb_eff) - 1'b1;
  assign blk_last = ({1'b0, blk_q} == blk_lim);

  dma_req_qual u_qual (
    .sw_req_i    (sw_req_i),
    .hw_sreq_i   (hw_sreq_i),
    .hw_breq_i   (hw_breq_i),
    .req_mask_i  (req_mask_i),
    .burst_only_i(burst_only_i),
    .trig_o      (trig)
  );

  dma_addr_calc #(.AW(AW)) u_src_addr (
    .end_addr_i(src_end_q), .rem_m1_i(rem_m1), .inc_i(ctrl_q[27:26]), .addr_o(rd_addr_o)
  );
  dma_addr_calc #(.AW(AW)) u_dst_addr (
    .end_addr_i(dst_end_q), .rem_m1_i(rem_m1), .inc_i(ctrl_q[31:30]), .addr_o(wr_addr_o)
  );

  assign go = (st_q == ST_IDLE) && !cfg_wr_i && en_q && (mode != MODE_STOP) &&
              (trig || auto_run_q);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      st_q       <= ST_IDLE;
      src_end_q  <= '0;
      dst_end_q  <= '0;
      ctrl_q     <= '0;
      en_q       <= 1'b0;
      err_q      <= 1'b0;
      done_q     <= 1'b0;
      auto_run_q <= 1'b0;
      blk_q      <= '0;
    end else begin
      done_q <= 1'b0;
      if (en_set_i) en_q <= 1'b1;
      unique case (st_q)
        ST_IDLE: begin
          if (cfg_wr_i) begin
            src_end_q  <= cfg_src_end_i;
            dst_end_q  <= cfg_dst_end_i;
            ctrl_q     <= cfg_ctrl_i;
            err_q      <= 1'b0;
            auto_run_q <= 1'b0;
            blk_q      <= '0;
          end else if (go) begin
            if (cfg_bad(ctrl_q)) begin
              err_q      <= 1'b1;
              en_q       <= 1'b0;
              auto_run_q <= 1'b0;
            end else begin
              st_q <= ST_RD;
              if (mode == MODE_AUTO) auto_run_q <= 1'b1;
            end
          end
        end
        ST_RD: st_q <= ST_WR;
        ST_WR: begin
          if (rem_m1 == '0) begin
            ctrl_q[2:0] <= MODE_STOP;
            en_q        <= 1'b0;
            done_q      <= 1'b1;
            auto_run_q  <= 1'b0;
            blk_q       <= '0;
            st_q        <= ST_IDLE;
          end else begin
            ctrl_q[CNT_LO +: CNT_W] <= rem_m1 - 1'b1;
            if (blk_last) begin
              blk_q <= '0;
              st_q  <= ST_IDLE;
            end else begin
              blk_q <= blk_q + 1'b1;
              st_q  <= ST_RD;
            end
          end
        end
        default: st_q <= ST_IDLE;
      endcase
    end
  end

  always_comb begin
    unique case (ctrl_q[25:24])
      2'd0:    wr_data_o = {24'h0, rd_data_i[7:0]};
      2'd1:    wr_data_o = {16'h0, rd_data_i[15:0]};
      default: wr_data_o = rd_data_i;
    endcase
  end

  assign rd_en_o   = (st_q == ST_RD);
  assign wr_en_o   = (st_q == ST_WR);
  assign wr_size_o = ctrl_q[25:24];
  assign ctrl_o    = ctrl_q;
  assign chan_en_o = en_q;
  assign busy_o    = (st_q != ST_IDLE);
  assign done_o    = done_q;
  assign err_o     = err_q;

  // R11
  no_rw_overlap_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(rd_en_o && wr_en_o));
  // R11
  wr_after_rd_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    wr_en_o |-> $past(rd_en_o));
  // R4
  done_stops_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |-> (!chan_en_o && ctrl_o[2:0] == MODE_STOP && ctrl_o[13:4] == '0));
  // R4
  count_step_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (wr_en_o && rem_m1 != '0) |=> (rem_m1 == $past(rem_m1) - 1'b1));
  // R3
  fixed_src_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (rd_en_o && ctrl_o[27:26] == INC_NONE) |-> (rd_addr_o == src_end_q));
  // R9
  err_no_move_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(err_o) |-> (!rd_en_o && !chan_en_o && $past(!busy_o)));
endmodule

// File: tb/dma_chan_engine_tb.sv
`timescale 1ns/1ps
module dma_chan_engine_tb_top;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        cfg_wr = 0, en_set = 0, req_mask = 0, burst_only = 0;
  logic        sw_req = 0, hw_sreq = 0, hw_breq = 0;
  logic [31:0] cfg_src = 0, cfg_dst = 0, cfg_ctrl = 0;
  logic        rd_en, wr_en, chan_en, busy, done, err;
  logic [31:0] rd_addr, wr_addr, wr_data, ctrl;
  logic [31:0] rd_data = 0;
  logic [1:0]  wr_size;

  logic [7:0] mem [0:511];
  logic [7:0] shadow [0:511];
  int n_chk = 0, n_fail = 0;

  always #2.5 clk = ~clk;

  dma_chan_engine dut_i (
    .clk_i(clk), .rst_ni(rst_n), .cfg_wr_i(cfg_wr), .cfg_src_end_i(cfg_src),
    .cfg_dst_end_i(cfg_dst), .cfg_ctrl_i(cfg_ctrl), .en_set_i(en_set),
    .req_mask_i(req_mask), .burst_only_i(burst_only), .sw_req_i(sw_req),
    .hw_sreq_i(hw_sreq), .hw_breq_i(hw_breq), .rd_en_o(rd_en), .rd_addr_o(rd_addr),
    .rd_data_i(rd_data), .wr_en_o(wr_en), .wr_addr_o(wr_addr), .wr_data_o(wr_data),
    .wr_size_o(wr_size), .ctrl_o(ctrl), .chan_en_o(chan_en), .busy_o(busy),
    .done_o(done), .err_o(err)
  );

  always @(posedge clk) begin
    if (rd_en)
      rd_data <= {mem[9'(rd_addr + 3)], mem[9'(rd_addr + 2)], mem[9'(rd_addr + 1)], mem[9'(rd_addr)]};
    if (wr_en)
      for (int b = 0; b < (1 << wr_size); b++) mem[9'(wr_addr + b)] <= wr_data[8*b +: 8];
  end

  task automatic chk(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic tick(input int n = 1);
    repeat (n) @(negedge clk);
  endtask

  function automatic logic [31:0] mk_ctrl(int sz, int si, int di, int n, int arb, int md);
    return {2'(di), 2'(sz), 2'(si), 2'(sz), 6'd0, 4'(arb), 10'(n - 1), 1'b0, 3'(md)};
  endfunction

  function automatic logic [31:0] end_ptr(int base, int inc, int n);
    return (inc == 3) ? 32'(base) : 32'(base + ((n - 1) << inc));
  endfunction

  task automatic init_mem(int seed);
    for (int i = 0; i < 512; i++) begin
      mem[i] = (i < 256) ? 8'(i * 37 + seed) : 8'hEE;
      shadow[i] = mem[i];
    end
  endtask

  task automatic model(int sz, int si, int di, int n);
    for (int k = 0; k < n; k++)
      for (int b = 0; b < (1 << sz); b++)
        shadow[9'('h100 + ((di == 3) ? 0 : (k << di)) + b)] =
          shadow[9'('h10 + ((si == 3) ? 0 : (k << si)) + b)];
  endtask

  task automatic load(int sz, int si, int di, int n, int arb, int md);
    cfg_src = end_ptr('h10, si, n);
    cfg_dst = end_ptr('h100, di, n);
    cfg_ctrl = mk_ctrl(sz, si, di, n, arb, md);
    cfg_wr = 1; en_set = 1; tick(); cfg_wr = 0; en_set = 0;
  endtask

  task automatic pulse(ref logic s);
    s = 1; tick(); s = 0;
  endtask

  task automatic wait_done(output bit seen);
    seen = 0;
    for (int c = 0; c < 3000 && !seen; c++) begin
      tick();
      if (done) seen = 1;
    end
  endtask

  function automatic bit mem_ok();
    for (int i = 'h100; i < 'h180; i++) if (mem[i] !== shadow[i]) return 0;
    return 1;
  endfunction

  initial begin
    repeat (150000) @(posedge clk);
    n_chk++; n_fail++;
    $display("FAIL watchdog actual=%h expected=%h", 32'd1, 32'd0);
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

  initial begin
    bit seen;
    logic [31:0] c0;
    tick(2);
    // R1 reset state
    chk(ctrl == 0 && !chan_en && !busy && !rd_en && !wr_en && !done && !err, "R1",
        {26'd0, chan_en, busy, rd_en, wr_en, done, err}, 0);
    rst_n = 1; tick();

    // R2 R3 R4 R6 R11: sweep all legal size/increment pairs in auto mode
    for (int sz = 0; sz < 3; sz++)
      for (int si = sz; si < 4; si++)
        for (int di = sz; di < 4; di++)
          for (int ni = 0; ni < 3; ni++)
            for (int ai = 0; ai < 2; ai++) begin
              int n, arb;
              n = (ni == 0) ? 1 : (ni == 1) ? 4 : 7;
              arb = ai * 2;
              init_mem(sz * 16 + si * 4 + di + ni);
              model(sz, si, di, n);
              load(sz, si, di, n, arb, 2);
              pulse(sw_req);
              wait_done(seen);
              chk(seen, "R4 done", 32'(seen), 1);
              tick();
              chk(mem_ok(), "R2/R3/R11 data", 32'(sz * 100 + si * 10 + di), 32'(n));
              chk(ctrl == mk_ctrl(sz, si, di, 1, arb, 0) && !chan_en, "R4 writeback",
                  ctrl, mk_ctrl(sz, si, di, 1, arb, 0));
            end

    // R5 basic mode: 6 items, blocks of 2, one request per block
    init_mem(5); model(0, 0, 0, 6);
    load(0, 0, 0, 6, 1, 1);
    pulse(hw_sreq); tick(10);
    chk(ctrl[13:4] == 3 && ctrl[2:0] == 1 && chan_en && !busy, "R5 block1", ctrl, mk_ctrl(0,0,0,4,1,1));
    pulse(hw_sreq); tick(10);
    chk(ctrl[13:4] == 1 && ctrl[2:0] == 1 && chan_en, "R5 block2", ctrl, mk_ctrl(0,0,0,2,1,1));
    pulse(hw_sreq); wait_done(seen); tick();
    chk(seen && mem_ok() && ctrl == mk_ctrl(0,0,0,1,1,0), "R5 final", ctrl, mk_ctrl(0,0,0,1,1,0));

    // R6 auto mode with single-cycle hardware request, block size 1
    init_mem(9); model(1, 1, 2, 5);
    load(1, 1, 2, 5, 0, 2);
    pulse(hw_sreq); wait_done(seen); tick();
    chk(seen && mem_ok(), "R6 auto runs", 32'(seen), 1);

    // R7 request mask
    init_mem(3); model(0, 0, 0, 3);
    req_mask = 1;
    load(0, 0, 0, 3, 0, 2);
    pulse(hw_sreq); pulse(hw_breq); tick(8);
    chk(ctrl == mk_ctrl(0,0,0,3,0,2) && chan_en && !busy, "R7 masked", ctrl, mk_ctrl(0,0,0,3,0,2));
    pulse(sw_req); wait_done(seen); tick();
    chk(seen && mem_ok(), "R7 sw start", 32'(seen), 1);
    req_mask = 0;

    // R8 burst-only
    init_mem(4); model(2, 2, 3, 2);
    burst_only = 1;
    load(2, 2, 3, 2, 0, 2);
    pulse(hw_sreq); tick(8);
    chk(ctrl == mk_ctrl(2,2,3,2,0,2) && chan_en && !busy, "R8 single ignored", ctrl, mk_ctrl(2,2,3,2,0,2));
    pulse(hw_breq); wait_done(seen); tick();
    chk(seen && mem_ok(), "R8 burst start", 32'(seen), 1);
    burst_only = 0;

    // R9 rejected: word size with byte increment
    init_mem(6);
    load(2, 0, 2, 3, 0, 2);
    c0 = mk_ctrl(2, 0, 2, 3, 0, 2);
    pulse(sw_req); tick(8);
    chk(err && !chan_en && ctrl == c0 && mem_ok(), "R9 reject", ctrl, c0);
    // R9 rejected: unsupported mode 3
    load(0, 0, 0, 2, 0, 3);
    chk(!err, "R9 cleared by load", 32'(err), 0);
    pulse(sw_req); tick(6);
    chk(err && mem_ok(), "R9 bad mode", 32'(err), 1);

    // R10 stop mode ignores requests
    load(0, 0, 0, 2, 0, 0);
    pulse(sw_req); tick(6);
    chk(!busy && !err && chan_en && ctrl == mk_ctrl(0,0,0,2,0,0) && mem_ok(), "R10 stop", ctrl, mk_ctrl(0,0,0,2,0,0));
    // R10 disabled channel ignores requests
    cfg_src = 'h10; cfg_dst = 'h100; cfg_ctrl = mk_ctrl(0,0,0,2,0,2);
    rst_n = 0; tick(); rst_n = 1; tick();
    cfg_wr = 1; tick(); cfg_wr = 0;
    pulse(sw_req); tick(6);
    chk(!busy && !chan_en && ctrl == mk_ctrl(0,0,0,2,0,2) && mem_ok(), "R10 disabled", ctrl, mk_ctrl(0,0,0,2,0,2));

    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end
endmodule